// File: doc/BRIEF.md
# Keyboard Character and Status Input Port

This block is a pair of read-only registers on an 8-bit microcomputer I/O bus. One register holds the last character delivered by a keyboard controller. The other is a status byte built from four configuration switches, a keyboard-ready flag, the disk motor state and the two serial receive-data lines. When a nonzero key code arrives, the block latches the code, raises the ready flag, and drives an active-low trigger to a counter/interrupt block low for one clock so the processor can be interrupted.

The processor reads a register by asserting chip-select and a one-clock read strobe, with a select bit that picks the register. The selected byte shows on the read bus in that same cycle. On the following clock edge the read clears what it reported: a status read drops the ready flag, and a data read zeroes the stored character. A key that arrives in the same cycle as a read takes priority over that read's clear.

The ready flag is held by a two-state machine. `STB_CLEAR` goes to `STB_SET` on an accepted key. `STB_SET` returns to `STB_CLEAR` on a status read with no new key, and stays in `STB_SET` otherwise. The trigger is driven by a second two-state machine. `TRG_IDLE` goes to `TRG_FIRE` on an accepted key. `TRG_FIRE` stays in `TRG_FIRE` if another key is accepted, and returns to `TRG_IDLE` if not. The trigger output is low only in `TRG_FIRE`.

Top module: `kbd_status_port`

## Requirements
- R1: After reset the stored character is 0x00, the ready flag is 0 and `ctr_trig` is high.
- R2: The status byte is {switch1, switch2, switch3, switch4, ready, motor_on, rxd_b, rxd_a}, from bit 7 down to bit 0. `cfg_sw[i]` is switch i+1 and appears at bit 7-i.
- R3: A key is accepted when `key_valid` is 1 and `key_code` is nonzero. An accepted key stores `key_code` and sets the ready flag (status bit 3) on the next clock edge.
- R4: A key with `key_code` equal to 0x00 is ignored. The stored character and the ready flag keep their values.
- R5: A status read returns the current status byte. On the next edge it clears the ready flag, unless a key is accepted in that cycle.
- R6: A data read returns the stored character. On the next edge it clears the character to 0x00, unless a key is accepted in that cycle.
- R7: `ctr_trig` is low for exactly the cycle after each cycle in which a key is accepted, and high in every other cycle.
- R8: A key accepted in the same cycle as a data read or a status read wins. The new code and a set ready flag remain after that edge.
- R9: A read occurs only when `cs` and `rd` are both 1. Otherwise `rd_data` is 0x00 and nothing is cleared.
- R10: `reg_sel` = 0 selects the status byte and `reg_sel` = 1 selects the stored character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Key code is offered this cycle |
| key_code | input | 8 | Character code from keyboard controller |
| cs | input | 1 | Port chip-select |
| rd | input | 1 | One-clock read strobe |
| reg_sel | input | 1 | 0 = status byte, 1 = character |
| motor_on | input | 1 | Motor-on bit from the system control latch |
| rxd_a | input | 1 | Serial channel A receive data |
| rxd_b | input | 1 | Serial channel B receive data |
| cfg_sw | input | 4 | Configuration switches 1..4 |
| rd_data | output | 8 | Read data bus |
| ctr_trig | output | 1 | Active-low one-cycle trigger to counter block |

## Verification
The assertions assume that `key_valid`, `key_code`, `cs`, `rd` and `reg_sel` are clean synchronous signals that change only between clock edges. They also assume that the read strobe lasts a single clock per access. The stimulus drives every input shortly after a rising edge and holds `rd` for one cycle per read. Keys are offered both alone and on consecutive cycles, so the trigger machine is exercised in its hold-low path as well as in single pulses.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
    // ready-flag machine
    typedef enum logic {
        STB_CLEAR = 1'b0,
        STB_SET   = 1'b1
    } stb_state_t;

    // trigger machine
    typedef enum logic {
        TRG_IDLE = 1'b0,
        TRG_FIRE = 1'b1
    } trg_state_t;

    // register select encoding
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_DATA   = 1'b1
    } reg_sel_t;
endpackage

// File: rtl/kbd_key_latch.sv
module kbd_key_latch #(
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_accept,
    input  logic [KEY_W-1:0] key_code,
    input  logic             data_clr,
    output logic [KEY_W-1:0] key_data
);
    logic [KEY_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (key_accept)
            data_q <= key_code;
        else if (data_clr)
            data_q <= '0;
    end

    assign key_data = data_q;

    assert_latch_new_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_accept |=> (key_data == $past(key_code)));

    assert_read_clears_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_clr && !key_accept) |=> (key_data == '0));
endmodule

// File: rtl/kbd_strobe_fsm.sv
module kbd_strobe_fsm
    import kbd_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_accept,
    input  logic status_clr,
    output logic ready
);
    stb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= STB_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STB_CLEAR: if (key_accept) state_d = STB_SET;
            STB_SET:   if (status_clr && !key_accept) state_d = STB_CLEAR;
            default:   state_d = STB_CLEAR;
        endcase
    end

    always_comb begin
        ready = (state_q == STB_SET);
    end

    assert_key_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_accept |=> ready);

    assert_status_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !key_accept) |=> !ready);

    assert_ready_needs_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_accept && !ready) |=> !ready);
endmodule

// File: rtl/kbd_trig_fsm.sv
module kbd_trig_fsm
    import kbd_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_accept,
    output logic trig_n
);
    trg_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TRG_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_IDLE: if (key_accept)  state_d = TRG_FIRE;
            TRG_FIRE: if (!key_accept) state_d = TRG_IDLE;
            default:  state_d = TRG_IDLE;
        endcase
    end

    always_comb begin
        trig_n = (state_q != TRG_FIRE);
    end

    assert_trig_low_after_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_accept |=> !trig_n);

    assert_trig_high_otherwise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !key_accept |=> trig_n);
endmodule

// File: rtl/kbd_status_port.sv
module kbd_status_port
    import kbd_port_pkg::*;
#(
    parameter int SW_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [SW_N+3:0]   key_code,
    input  logic              cs,
    input  logic              rd,
    input  logic              reg_sel,
    input  logic              motor_on,
    input  logic              rxd_a,
    input  logic              rxd_b,
    input  logic [SW_N-1:0]   cfg_sw,
    output logic [SW_N+3:0]   rd_data,
    output logic              ctr_trig
);
    localparam int BUS_W   = SW_N + 4;
    localparam int RDY_BIT = 3;
    localparam int MOT_BIT = 2;
    localparam int RXB_BIT = 1;
    localparam int RXA_BIT = 0;

    logic             key_accept;
    logic             rd_hit;
    logic             status_clr;
    logic             data_clr;
    logic             ready;
    logic [BUS_W-1:0] key_data;
    logic [BUS_W-1:0] status_word;

    assign key_accept = key_valid && (key_code != '0);
    assign rd_hit     = cs && rd;
    assign status_clr = rd_hit && (reg_sel_t'(reg_sel) == SEL_STATUS);
    assign data_clr   = rd_hit && (reg_sel_t'(reg_sel) == SEL_DATA);

    // switch i+1 lands at bit BUS_W-1-i
    for (genvar i = 0; i < SW_N; i++) begin : g_sw_pack
        assign status_word[BUS_W-1-i] = cfg_sw[i];
    end
    assign status_word[RDY_BIT] = ready;
    assign status_word[MOT_BIT] = motor_on;
    assign status_word[RXB_BIT] = rxd_b;
    assign status_word[RXA_BIT] = rxd_a;

    kbd_key_latch #(.KEY_W(BUS_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_accept (key_accept),
        .key_code   (key_code),
        .data_clr   (data_clr),
        .key_data   (key_data)
    );

    kbd_strobe_fsm u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_accept (key_accept),
        .status_clr (status_clr),
        .ready      (ready)
    );

    kbd_trig_fsm u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_accept (key_accept),
        .trig_n     (ctr_trig)
    );

    always_comb begin
        if (!rd_hit)
            rd_data = '0;
        else if (reg_sel_t'(reg_sel) == SEL_DATA)
            rd_data = key_data;
        else
            rd_data = status_word;
    end

    assert_zero_code_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_code == '0 && !data_clr) |=> $stable(key_data));

    assert_no_read_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit && !key_accept) |=> $stable(key_data));

    assert_key_wins_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_accept && rd_hit) |=> (ready && key_data != '0));

    always_comb begin
        if (rst_n && !rd_hit)
            assert_idle_bus_R9: assert (rd_data == '0);
    end
endmodule

// File: tb/kbd_status_port_tb_top.sv
`timescale 1ns/100ps
module kbd_status_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [7:0] key_code = '0;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       reg_sel = 1'b0;
    logic       motor_on = 1'b0;
    logic       rxd_a = 1'b0;
    logic       rxd_b = 1'b0;
    logic [3:0] cfg_sw = '0;
    logic [7:0] rd_data;
    logic       ctr_trig;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       exp_trig = 1'b1;
    bit         done = 0;

    always #2.5 clk = ~clk;

    kbd_status_port dut_i (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .cs(cs), .rd(rd), .reg_sel(reg_sel), .motor_on(motor_on),
        .rxd_a(rxd_a), .rxd_b(rxd_b), .cfg_sw(cfg_sw),
        .rd_data(rd_data), .ctr_trig(ctr_trig)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // expected trigger level from the requirement (R7)
    always @(posedge clk) begin
        if (!rst_n) exp_trig <= 1'b1;
        else        exp_trig <= !(key_valid && key_code != 8'h00);
    end

    // monitor: reads are compared against the scoreboard; trigger every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (ctr_trig !== exp_trig) begin
                fails++;
                $display("FAIL R7: ctr_trig actual %b expected %b", ctr_trig, exp_trig);
            end
            if (cs && rd) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9: unexpected read actual %02h expected none", rd_data);
                end else begin
                    check8(rd_data, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    task automatic drive(input logic kv, input logic [7:0] kc,
                         input logic c, input logic r, input logic s);
        @(posedge clk); #1;
        key_valid = kv; key_code = kc; cs = c; rd = r; reg_sel = s;
    endtask

    task automatic rd_reg(input logic s, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        drive(1'b0, 8'h00, 1'b1, 1'b1, s);
    endtask

    task automatic key_rd(input logic [7:0] kc, input logic s,
                          input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        drive(1'b1, kc, 1'b1, 1'b1, s);
    endtask

    task automatic key(input logic [7:0] kc);
        drive(1'b1, kc, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        cfg_sw = 4'b0001; motor_on = 1'b1; rxd_b = 1'b0; rxd_a = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        rd_reg(1'b0, 8'h85, "R1 R2 R10 reset status");
        rd_reg(1'b1, 8'h00, "R1 R10 reset data");
        idle();
        cfg_sw = 4'b1010; motor_on = 1'b0; rxd_b = 1'b1; rxd_a = 1'b0;
        rd_reg(1'b0, 8'h52, "R2 second pattern");
        key(8'h41);
        rd_reg(1'b0, 8'h5A, "R3 R5 ready set");
        rd_reg(1'b0, 8'h52, "R5 ready cleared");
        rd_reg(1'b1, 8'h41, "R3 R6 code stored");
        rd_reg(1'b1, 8'h00, "R6 code cleared");
        key(8'h41);
        rd_reg(1'b0, 8'h5A, "R3 ready again");
        key(8'h00);
        rd_reg(1'b0, 8'h52, "R4 zero code no ready");
        rd_reg(1'b1, 8'h41, "R4 zero code kept data");
        key(8'h33);
        key_rd(8'h5A, 1'b1, 8'h33, "R8 data read with key");
        rd_reg(1'b1, 8'h5A, "R8 new key survives data read");
        rd_reg(1'b0, 8'h5A, "R8 ready still set");
        key_rd(8'h22, 1'b0, 8'h52, "R8 status read with key");
        rd_reg(1'b0, 8'h5A, "R8 ready survives status read");
        rd_reg(1'b1, 8'h22, "R8 code after status race");
        key(8'h11);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
        @(negedge clk); check8(rd_data, 8'h00, "R9 rd without cs");
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        @(negedge clk); check8(rd_data, 8'h00, "R9 cs without rd");
        rd_reg(1'b0, 8'h5A, "R9 ready not cleared");
        rd_reg(1'b1, 8'h11, "R9 data not cleared");
        idle();
        repeat (3) @(posedge clk);
        check8(8'(exp_q.size()), 8'h00, "R6 scoreboard drained");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule